// File: doc/BRIEF.md
# Field Shifter with Exponent Detection

This block is a single-cycle shift and bit-field unit for a 32-bit datapath. In one pass through combinational logic it can do any of these: shift a word left or right, logically or arithmetically, by a signed amount; set, clear, toggle or test one chosen bit; pull a bit field out of a word and right-justify it, with zero or sign fill above it; write the low bits of a second word into a chosen field of the first; or count the redundant sign bits of a word to give its normalising exponent. A register at the output holds the result and a one-bit flag.

The caller presents the op code and operands before a clock edge. The result and flag for those inputs show up at the outputs after that edge. Each clock edge accepts one new operation. There is no handshake, and the output register loads on every edge that is not in reset.

Top module: `field_shifter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` and `flag` are cleared to zero.
- R2: The outputs change only at a rising clock edge. The result for the inputs sampled at one edge appears right after that edge and holds until the next edge.
- R3: Op code 0 is a logical shift by the signed 8-bit `shift_amt`. A positive amount shifts left, a negative amount shifts right with zero fill, and a magnitude of 32 or more gives zero.
- R4: Op code 1 is an arithmetic shift. A positive amount shifts left with zero fill, and a negative amount shifts right while copying bit 31. For magnitudes of 32 or more, the result is zero for a left shift and 32 copies of bit 31 for a right shift.
- R5: Op codes 2, 3 and 4 set, clear and toggle, respectively, bit `bit_pos` of `opnd_a`. All other bits pass through unchanged.
- R6: Op code 5 tests bit `bit_pos` of `opnd_a`. The result equals `opnd_a`, and `flag` is 1 exactly when the tested bit is 0.
- R7: Op code 6 extracts the field of `fld_len` bits whose lowest bit is at `bit_pos`. The field is right-justified with zero fill above it. Lengths above 32 act as 32, a length of 0 gives zero, and field bits that would lie above bit 31 read as zero.
- R8: Op code 7 extracts the same field as op code 6 but fills the bits above it with the field's top bit. A length of 0 still gives zero.
- R9: Op code 8 replaces the field of `fld_len` bits at `bit_pos` in `opnd_a` with the low bits of `opnd_b`. Field bits that would fall above bit 31 are dropped, and a length of 0 returns `opnd_a` unchanged.
- R10: Op code 9 returns the count of leading bits equal to bit 31, minus one. The result is in 0..31, and an all-zero or all-one operand gives 31.
- R11: For every op code except 5, `flag` is 1 exactly when `result` is zero.
- R12: Op codes 10 to 15 give a zero result, so `flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 4 | Operation select (0..9 defined) |
| opnd_a | input | 32 | Main operand |
| opnd_b | input | 32 | Field source for deposit |
| shift_amt | input | 8 | Signed shift amount, two's complement |
| bit_pos | input | 5 | Bit index or field start position |
| fld_len | input | 6 | Field length in bits |
| result | output | 32 | Registered result |
| flag | output | 1 | Registered zero flag, or bit-test flag for op code 5 |

## Verification
Each assertion compares the registered outputs with the inputs sampled one edge earlier. The assertions therefore assume that the inputs are settled at each rising edge and that the cycle before the edge was out of reset. The stimulus meets this by changing every input on the falling edge only, and by starting with several reset cycles. The sweeps cover every signed shift amount, every bit position, and field lengths both up to and past the word width. The length range includes the zero-length and over-long cases that the field assertions rely on.

// File: rtl/fsh_pkg.sv
// Shared definitions for the field shifter.
// Assumes a 4-bit op code; values above OP_DEXP are reserved.
package fsh_pkg;
    typedef enum logic [3:0] {
        OP_LSH   = 4'd0,
        OP_ASH   = 4'd1,
        OP_BSET  = 4'd2,
        OP_BCLR  = 4'd3,
        OP_BTGL  = 4'd4,
        OP_BTST  = 4'd5,
        OP_FEXT  = 4'd6,
        OP_FEXTS = 4'd7,
        OP_FDEP  = 4'd8,
        OP_DEXP  = 4'd9
    } fsh_op_e;
endpackage

// File: rtl/fsh_shift_core.sv
// Signed-amount barrel shifter.
// A positive amount shifts left and a negative amount shifts right.
// Magnitudes of WIDTH or more saturate: zero, or sign fill for an
// arithmetic right shift. Assumes WIDTH is a power of two.
module fsh_shift_core #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    input  logic             arith,
    output logic [WIDTH-1:0] dout
);
    localparam int POS_W = $clog2(WIDTH);

    logic [AMT_W:0]   ext;
    logic [AMT_W:0]   mag;
    logic             neg;
    logic             big;
    logic [POS_W-1:0] sh;

    // Take the magnitude of the signed amount and flag saturation.
    always_comb begin
        neg = amt[AMT_W-1];
        ext = {amt[AMT_W-1], amt};
        mag = neg ? (~ext + 1'b1) : ext;
        big = (mag >= (AMT_W+1)'(WIDTH));
        sh  = mag[POS_W-1:0];
    end

    // Pick the direction and fill for the shifted word.
    always_comb begin
        if (!neg)
            dout = big ? '0 : (din << sh);
        else if (arith)
            dout = big ? {WIDTH{din[WIDTH-1]}} : WIDTH'($signed(din) >>> sh);
        else
            dout = big ? '0 : (din >> sh);
    end
endmodule

// File: rtl/fsh_field.sv
// Bit-field extract and deposit.
// A length above WIDTH acts as WIDTH. Field bits that would lie above
// the top of the word are dropped.
module fsh_field #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]         a,
    input  logic [WIDTH-1:0]         b,
    input  logic [$clog2(WIDTH)-1:0] pos,
    input  logic [$clog2(WIDTH):0]   len,
    input  logic                     sext,
    output logic [WIDTH-1:0]         ext_y,
    output logic [WIDTH-1:0]         dep_y
);
    localparam int POS_W = $clog2(WIDTH);
    localparam int LEN_W = POS_W + 1;

    logic [LEN_W-1:0] len_eff;
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] field;
    logic [POS_W-1:0] top_idx;
    logic             top_bit;
    logic [WIDTH-1:0] pmask;

    // Clamp the length and build a mask of its low ones.
    always_comb begin
        len_eff = (len > LEN_W'(WIDTH)) ? LEN_W'(WIDTH) : len;
        mask    = {WIDTH{1'b1}} >> (LEN_W'(WIDTH) - len_eff);
    end

    // Right-justify the field and optionally sign-extend it.
    always_comb begin
        shifted = a >> pos;
        field   = shifted & mask;
        top_idx = POS_W'(len_eff - 1'b1);
        top_bit = (len_eff != '0) && shifted[top_idx];
        ext_y   = (sext && top_bit) ? (field | ~mask) : field;
    end

    // Insert the low bits of b at pos and keep every other bit of a.
    always_comb begin
        pmask = mask << pos;
        dep_y = (a & ~pmask) | ((b << pos) & pmask);
    end
endmodule

// File: rtl/fsh_expdet.sv
// Redundant-sign-bit counter.
// Returns the number of leading bits equal to the MSB, minus one.
// An all-equal word gives WIDTH-1.
module fsh_expdet #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] exp_y
);
    localparam int POS_W = $clog2(WIDTH);

    logic [WIDTH-2:0] diff;
    logic [POS_W-1:0] cnt;
    logic             found;

    // Mark the bits that differ from the sign, then find the first one from the top.
    always_comb begin
        diff  = din[WIDTH-2:0] ^ {(WIDTH-1){din[WIDTH-1]}};
        cnt   = POS_W'(WIDTH-1);
        found = 1'b0;
        for (int i = WIDTH-2; i >= 0; i--) begin
            if (!found && diff[i]) begin
                cnt   = POS_W'(WIDTH-2-i);
                found = 1'b1;
            end
        end
        exp_y = WIDTH'(cnt);
    end
endmodule

// File: rtl/field_shifter.sv
// Top level of the single-cycle shift, bit and field unit.
// Selects one of the sub-results by op code and registers it with a flag.
// Inputs are sampled at each rising edge. Reset is synchronous and active low.
module field_shifter #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    parameter int POS_W = $clog2(WIDTH),
    parameter int LEN_W = $clog2(WIDTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [AMT_W-1:0] shift_amt,
    input  logic [POS_W-1:0] bit_pos,
    input  logic [LEN_W-1:0] fld_len,
    output logic [WIDTH-1:0] result,
    output logic             flag
);
    import fsh_pkg::*;

    fsh_op_e          op;
    logic [WIDTH-1:0] sh_y;
    logic [WIDTH-1:0] ext_y;
    logic [WIDTH-1:0] dep_y;
    logic [WIDTH-1:0] exp_y;
    logic [WIDTH-1:0] sel;
    logic [WIDTH-1:0] nxt_res;
    logic             nxt_flag;

    assign op  = fsh_op_e'(op_code);
    assign sel = WIDTH'(1) << bit_pos;

    fsh_shift_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_shift (
        .din   (opnd_a),
        .amt   (shift_amt),
        .arith (op == OP_ASH),
        .dout  (sh_y)
    );

    fsh_field #(.WIDTH(WIDTH)) u_field (
        .a     (opnd_a),
        .b     (opnd_b),
        .pos   (bit_pos),
        .len   (fld_len),
        .sext  (op == OP_FEXTS),
        .ext_y (ext_y),
        .dep_y (dep_y)
    );

    fsh_expdet #(.WIDTH(WIDTH)) u_exp (
        .din   (opnd_a),
        .exp_y (exp_y)
    );

    // Pick the result for the current op code and form its flag.
    always_comb begin
        unique case (op)
            OP_LSH, OP_ASH:    nxt_res = sh_y;
            OP_BSET:           nxt_res = opnd_a | sel;
            OP_BCLR:           nxt_res = opnd_a & ~sel;
            OP_BTGL:           nxt_res = opnd_a ^ sel;
            OP_BTST:           nxt_res = opnd_a;
            OP_FEXT, OP_FEXTS: nxt_res = ext_y;
            OP_FDEP:           nxt_res = dep_y;
            OP_DEXP:           nxt_res = exp_y;
            default:           nxt_res = '0;
        endcase
        nxt_flag = (op == OP_BTST) ? ((opnd_a & sel) == '0) : (nxt_res == '0);
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag   <= 1'b0;
        end else begin
            result <= nxt_res;
            flag   <= nxt_flag;
        end
    end
endmodule

// File: rtl/field_shifter_chk.sv
// Checker for field_shifter. It compares the registered outputs with the
// inputs seen one edge earlier. Assumes the inputs are stable at each edge.
module field_shifter_chk #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    parameter int POS_W = 5,
    parameter int LEN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_code,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [AMT_W-1:0] shift_amt,
    input logic [POS_W-1:0] bit_pos,
    input logic [LEN_W-1:0] fld_len,
    input logic [WIDTH-1:0] result,
    input logic             flag
);
    import fsh_pkg::*;

    logic big_amt;
    logic sel_bit;
    assign big_amt = ($signed(shift_amt) >= $signed((AMT_W+1)'(WIDTH))) ||
                     ($signed(shift_amt) <= -$signed((AMT_W+1)'(WIDTH)));
    assign sel_bit = opnd_a[bit_pos];

    // R11: zero flag tracks the result for every op except the bit test.
    p_zero_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) != OP_BTST) |-> (flag == (result == '0)));

    // R6: the bit test flags a zero bit and passes the operand through.
    p_bit_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OP_BTST) |->
            (flag == !$past(sel_bit) && result == $past(opnd_a)));

    // R3: a logical shift of magnitude 32 or more clears the word.
    p_big_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OP_LSH && $past(big_amt)) |-> (result == '0));

    // R9: a zero-length deposit leaves the operand unchanged.
    p_dep_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OP_FDEP && $past(fld_len) == '0) |->
            (result == $past(opnd_a)));

    // R10: the exponent never exceeds WIDTH-1.
    p_exp_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OP_DEXP) |-> (result <= WIDTH'(WIDTH-1)));

    // R12: reserved op codes give zero.
    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) > OP_DEXP) |-> (result == '0 && flag));
endmodule

bind field_shifter field_shifter_chk #(
    .WIDTH(WIDTH), .AMT_W(AMT_W), .POS_W(POS_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .shift_amt(shift_amt), .bit_pos(bit_pos),
    .fld_len(fld_len), .result(result), .flag(flag)
);

// File: tb/field_shifter_test.sv
// Sweep bench for field_shifter. Expected values come from integer arithmetic.
module field_shifter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [7:0]  shift_amt = '0;
    logic [4:0]  bit_pos = '0;
    logic [5:0]  fld_len = '0;
    logic [31:0] result;
    logic        flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    field_shifter uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .shift_amt(shift_amt), .bit_pos(bit_pos),
        .fld_len(fld_len), .result(result), .flag(flag)
    );

    always #2 clk = ~clk;

    function automatic longint p2(int n);
        longint v = 1;
        for (int k = 0; k < n; k++) v = v * 2;
        return v;
    endfunction

    // Reference model built from arithmetic on wide integers.
    function automatic logic [32:0] model(int op, longint a, longint b, int amt, int pos, int len);
        longint r = 0;
        longint m32 = p2(32);
        longint sa;
        int n;
        int l;
        int cnt;
        logic [31:0] av;
        logic f;
        av = a[31:0];
        sa = (a >= p2(31)) ? a - m32 : a;
        l = (len > 32) ? 32 : len;
        case (op)
            0, 1: begin
                n = (amt < 0) ? -amt : amt;
                if (n > 40) n = 40;
                if (amt >= 0) r = (a * p2(n)) % m32;
                else if (op == 0) r = a / p2(n);
                else begin
                    if (sa < 0) r = -(((-sa) + p2(n) - 1) / p2(n));
                    else r = sa / p2(n);
                    if (r < 0) r = r + m32;
                end
            end
            2: r = ((a / p2(pos)) % 2 == 1) ? a : a + p2(pos);
            3: r = ((a / p2(pos)) % 2 == 1) ? a - p2(pos) : a;
            4: r = ((a / p2(pos)) % 2 == 1) ? a - p2(pos) : a + p2(pos);
            5: r = a;
            6, 7: begin
                r = (a / p2(pos)) % p2(l);
                if (op == 7 && l > 0 && r >= p2(l - 1)) r = (r - p2(l) + m32) % m32;
            end
            8: r = (a - ((a / p2(pos)) % p2(l)) * p2(pos) + ((b % p2(l)) * p2(pos)) % m32) % m32;
            9: begin
                cnt = 0;
                for (int i = 30; i >= 0; i--) begin
                    if (av[i] != av[31]) break;
                    cnt++;
                end
                r = cnt;
            end
            default: r = 0;
        endcase
        f = (op == 5) ? ((a / p2(pos)) % 2 == 0) : (r == 0);
        return {f, r[31:0]};
    endfunction

    task automatic check(string req, logic [31:0] act_r, logic act_f, logic [32:0] exp);
        n_chk++;
        if (act_r !== exp[31:0] || act_f !== exp[32]) begin
            n_bad++;
            $display("FAIL %s: result=%h flag=%b expected result=%h flag=%b",
                     req, act_r, act_f, exp[31:0], exp[32]);
        end
    endtask

    // Apply one operation on the falling edge and compare after the next rising edge.
    task automatic run(string req, int op, logic [31:0] a, logic [31:0] b, int amt, int pos, int len);
        @(negedge clk);
        op_code = 4'(op); opnd_a = a; opnd_b = b;
        shift_amt = 8'(amt); bit_pos = 5'(pos); fld_len = 6'(len);
        @(posedge clk); #1;
        check(req, result, flag, model(op, longint'(a), longint'(b), amt, pos, len));
    endtask

    logic [31:0] vals [6] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7F3C_A5E1, 32'hC0DE_1234, 32'h0000_8421};

    initial begin
        logic [31:0] lf;
        logic [32:0] prev;
        // R1: reset clears outputs even with live inputs.
        op_code = 4'd0; opnd_a = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1 check("R1", result, flag, 33'h0);
        @(negedge clk) rst_n = 1'b1;

        // R3 and R4: every signed amount, logical and arithmetic.
        for (int op = 0; op < 2; op++)
            for (int v = 0; v < 6; v++)
                for (int amt = -128; amt < 128; amt++)
                    run(op == 0 ? "R3" : "R4", op, vals[v], 32'h0, amt, 0, 0);

        // R5 and R6: every bit position.
        for (int op = 2; op < 6; op++)
            for (int v = 0; v < 6; v++)
                for (int p = 0; p < 32; p++)
                    run(op == 5 ? "R6" : "R5", op, vals[v], 32'h0, 0, p, 0);

        // R7 and R8: every position and lengths past the word width.
        for (int op = 6; op < 8; op++)
            for (int v = 2; v < 5; v++)
                for (int p = 0; p < 32; p++)
                    for (int l = 0; l < 41; l++)
                        run(op == 6 ? "R7" : "R8", op, vals[v], 32'h0, 0, p, l);
        run("R7", 6, 32'hFFFF_FFFF, 32'h0, 0, 0, 63);

        // R9: deposit across positions and lengths.
        for (int p = 0; p < 32; p++)
            for (int l = 0; l < 41; l++)
                run("R9", 8, 32'h1234_5678, 32'hA5C3_9F0E, 0, p, l);

        // R10: exponent on single-bit and single-zero words plus an LFSR run.
        for (int k = 0; k < 32; k++) begin
            run("R10", 9, 32'h1 << k, 32'h0, 0, 0, 0);
            run("R10", 9, ~(32'h1 << k), 32'h0, 0, 0, 0);
        end
        run("R10", 9, 32'h0, 32'h0, 0, 0, 0);
        lf = 32'hACE1_2468;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run("R10", 9, lf >> (i % 32), 32'h0, 0, 0, 0);
        end

        // R11 and R12: zero results across ops, and reserved codes.
        run("R11", 2, 32'h0, 32'h0, 0, 3, 0);
        run("R11", 3, 32'h0000_0010, 32'h0, 0, 4, 0);
        for (int op = 10; op < 16; op++)
            run("R12", op, 32'hFFFF_0000, 32'h1234, 5, 7, 9);

        // R2: the output holds until the next rising edge.
        run("R2", 4, 32'h0F0F_0F0F, 32'h0, 0, 4, 0);
        prev = {flag, result};
        @(negedge clk);
        op_code = 4'd0; opnd_a = 32'h1; shift_amt = 8'd3;
        #1 check("R2", result, flag, prev);
        @(posedge clk); #1;
        check("R2", result, flag, 33'h0_0000_0008);

        // R1: reset in the middle of a run clears the outputs again.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", result, flag, 33'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule